// File: doc/BRIEF.md
# Packet Slack Priority Estimator

This unit sits beside a core's network injection port and tags every outgoing miss request with a 5-bit slack value. A larger value means the packet can wait longer in the routers without costing the core any time, so schedulers downstream treat it as less urgent. The value is built from the core's other outstanding miss requests at the moment the new one leaves, which are its predecessors. Three things enter into it: how many of those predecessors are expected to go all the way past the L2, whether the new request itself is expected to hit in the L2, and how much farther the most distant predecessor travels compared with the new packet.

The block keeps a table of outstanding requests, each with its predicted L2 outcome and its Manhattan hop count. It also runs a small history-based L2 miss predictor that learns from the real outcome reported on each completion. A request is issued with its destination coordinates and gets back a table slot, its tag, and its priority in the same cycle. The completion carries that tag and the true L2 outcome.

Top module: `slack_prio_estimator`

## Requirements
- R1: After reset the table is empty, `issue_ready` is 1, the miss history is all zero, and an issue then gets priority 5'b00100.
- R2: The hop count of a request is |dst_x − src_x| + |dst_y − src_y|. It is taken from the source coordinates present at issue and is stored with the entry.
- R3: `prio[1:0]` is the largest stored hop count among the valid entries (0 if none) minus the new packet's hop count. A negative result gives 0 and a result above 3 gives 3.
- R4: `prio[4:3]` is the number of valid entries whose stored prediction was "L2 miss", saturating at 3.
- R5: `prio[2]` is 1 when the new request is predicted to hit in the L2 and 0 when it is predicted to miss. Each entry stores that prediction.
- R6: The prediction is "miss" when at least THRESH (default 2) of the last HIST (default 4) completion outcomes were L2 misses. Each accepted completion shifts its outcome into the history.
- R7: `issue_tag` is the lowest free slot index. `issue_ready` is 0 exactly when all ENTRIES (default 8) slots hold requests. An issue while not ready makes no entry.
- R8: A completion whose tag names a valid entry frees that slot. A completion naming a free slot is ignored: no slot changes and the history does not change.
- R9: When a completion and an issue fall in the same cycle, the issue's priority and prediction use the state from before that completion.
- R10: `prio_valid` is 1 exactly when `issue_valid` and `issue_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_x | input | CW | This core's X coordinate |
| src_y | input | CW | This core's Y coordinate |
| issue_valid | input | 1 | A miss request is being issued this cycle |
| issue_dst_x | input | CW | Destination X of the issued request |
| issue_dst_y | input | CW | Destination Y of the issued request |
| issue_ready | output | 1 | A table slot is free |
| issue_tag | output | log2(ENTRIES) | Slot given to the issued request |
| prio_valid | output | 1 | The issue is accepted and `prio` is meaningful |
| prio | output | 5 | Slack priority {pred-miss count, own-hit, hop slack} |
| cmpl_valid | input | 1 | A request completes this cycle |
| cmpl_tag | input | log2(ENTRIES) | Tag of the completing request |
| cmpl_l2_miss | input | 1 | The completing request actually missed in the L2 |

## Verification
The bench targets the hop-difference clamp at both ends, across every predecessor destination on the grid. A design that wrapped the subtraction would give a large slack to packets that travel farther than their predecessors. It drives every 4-bit completion history against the threshold, which exposes an off-by-one comparison or a history shifted in the wrong direction. It also fills the table to check saturation of the miss count and refusal of a ninth issue, then sends duplicate and same-cycle completions. A design that trained on stale tags, or that let a completion hide a predecessor in the same cycle, would show a changed hit bit or a wrong tag.

// File: rtl/slack_prio_pkg.sv
`timescale 1ns/1ps
package slack_prio_pkg;

  // Manhattan distance between two grid points
  function automatic int manhattan(int ax, int ay, int bx, int by);
    int dx;
    int dy;
    dx = (ax > bx) ? ax - bx : bx - ax;
    dy = (ay > by) ? ay - by : by - ay;
    return dx + dy;
  endfunction

  // Difference of hop counts, clamped into two bits
  function automatic logic [1:0] hop_slack(int max_pred, int own);
    int d;
    d = max_pred - own;
    if (d < 0) return 2'd0;
    if (d > 3) return 2'd3;
    return 2'(d);
  endfunction

  // Count saturating into two bits
  function automatic logic [1:0] sat2(int n);
    return (n > 3) ? 2'd3 : 2'(n);
  endfunction

endpackage

// File: rtl/slk_l2_predictor.sv
`timescale 1ns/1ps
module slk_l2_predictor #(
  parameter int HIST   = 4,
  parameter int THRESH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic train_valid,
  input  logic train_miss,
  output logic predict_miss
);
  logic [HIST-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else if (train_valid) hist_q <= {hist_q[HIST-2:0], train_miss};
  end

  assign predict_miss = ($countones(hist_q) >= THRESH);

  // R6: history only moves on an accepted completion
  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !train_valid |=> $stable(hist_q));
  // R6: newest outcome lands in the low bit
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    train_valid |=> hist_q[0] == $past(train_miss));
endmodule

// File: rtl/slk_pending_list.sv
`timescale 1ns/1ps
module slk_pending_list #(
  parameter int ENTRIES = 8,
  parameter int HW      = 4,
  localparam int TW     = $clog2(ENTRIES),
  localparam int CNTW   = $clog2(ENTRIES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_fire,
  input  logic            alloc_predmiss,
  input  logic [HW-1:0]   alloc_hops,
  input  logic            free_valid,
  input  logic [TW-1:0]   free_tag,
  output logic            full,
  output logic [TW-1:0]   alloc_idx,
  output logic            free_hit,
  output logic [HW-1:0]   max_hops,
  output logic [CNTW-1:0] miss_cnt
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] pm_q;
  logic [HW-1:0]      hops_q [ENTRIES];
  logic               found;

  always_comb begin
    found     = 1'b0;
    alloc_idx = '0;
    max_hops  = '0;
    miss_cnt  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !found) begin
        alloc_idx = TW'(i);
        found     = 1'b1;
      end
      if (valid_q[i]) begin
        if (hops_q[i] > max_hops) max_hops = hops_q[i];
        miss_cnt = miss_cnt + CNTW'(pm_q[i]);
      end
    end
    full = !found;
  end

  assign free_hit = free_valid && valid_q[free_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      pm_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) hops_q[i] <= '0;
    end else begin
      if (free_hit) valid_q[free_tag] <= 1'b0;
      if (alloc_fire) begin
        valid_q[alloc_idx] <= 1'b1;
        pm_q[alloc_idx]    <= alloc_predmiss;
        hops_q[alloc_idx]  <= alloc_hops;
      end
    end
  end

  // R7: an accepted issue occupies its slot next cycle
  assert_alloc_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> valid_q[$past(alloc_idx)]);
  // R8: a matching completion releases its slot
  assert_free_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_hit |=> !valid_q[$past(free_tag)]);
  // R8: with neither event the occupancy holds
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_fire && !free_hit) |=> $stable(valid_q));
endmodule

// File: rtl/slack_prio_estimator.sv
`timescale 1ns/1ps
module slack_prio_estimator #(
  parameter int CW      = 3,
  parameter int ENTRIES = 8,
  parameter int HIST    = 4,
  parameter int THRESH  = 2,
  localparam int TW     = $clog2(ENTRIES),
  localparam int HW     = CW + 1,
  localparam int CNTW   = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic          issue_valid,
  input  logic [CW-1:0] issue_dst_x,
  input  logic [CW-1:0] issue_dst_y,
  output logic          issue_ready,
  output logic [TW-1:0] issue_tag,
  output logic          prio_valid,
  output logic [4:0]    prio,
  input  logic          cmpl_valid,
  input  logic [TW-1:0] cmpl_tag,
  input  logic          cmpl_l2_miss
);
  import slack_prio_pkg::*;

  logic            list_full;
  logic            free_hit;
  logic            pred_miss;
  logic [HW-1:0]   own_hops;
  logic [HW-1:0]   max_hops;
  logic [CNTW-1:0] miss_cnt;
  logic            issue_fire;

  assign own_hops    = HW'(manhattan(int'(src_x), int'(src_y),
                                     int'(issue_dst_x), int'(issue_dst_y)));
  assign issue_ready = !list_full;
  assign issue_fire  = issue_valid && issue_ready;
  assign prio_valid  = issue_fire;
  assign prio        = {sat2(int'(miss_cnt)), !pred_miss,
                        hop_slack(int'(max_hops), int'(own_hops))};

  slk_l2_predictor #(.HIST(HIST), .THRESH(THRESH)) u_pred (
    .clk          (clk),
    .rst_n        (rst_n),
    .train_valid  (free_hit),
    .train_miss   (cmpl_l2_miss),
    .predict_miss (pred_miss)
  );

  slk_pending_list #(.ENTRIES(ENTRIES), .HW(HW)) u_list (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_fire     (issue_fire),
    .alloc_predmiss (pred_miss),
    .alloc_hops     (own_hops),
    .free_valid     (cmpl_valid),
    .free_tag       (cmpl_tag),
    .full           (list_full),
    .alloc_idx      (issue_tag),
    .free_hit       (free_hit),
    .max_hops       (max_hops),
    .miss_cnt       (miss_cnt)
  );

  // R3: no predecessor farther than the packet gives zero slack
  assert_hop_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_valid && max_hops <= own_hops) |-> prio[1:0] == 2'd0);
  // R5: a predicted miss clears the own-hit bit
  assert_own_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_valid && pred_miss) |-> !prio[2]);
  // R4: no predicted-miss predecessors gives a zero count field
  assert_miss_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_valid && miss_cnt == '0) |-> prio[4:3] == 2'd0);
endmodule

// File: tb/slack_prio_estimator_tb.sv
`timescale 1ns/1ps
module slack_prio_estimator_tb;
  localparam int NE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_x = 3'd3, src_y = 3'd4;
  logic       issue_valid = 1'b0;
  logic [2:0] issue_dst_x = '0, issue_dst_y = '0;
  logic       issue_ready;
  logic [2:0] issue_tag;
  logic       prio_valid;
  logic [4:0] prio;
  logic       cmpl_valid = 1'b0;
  logic [2:0] cmpl_tag = '0;
  logic       cmpl_l2_miss = 1'b0;

  slack_prio_estimator u_dut (
    .clk(clk), .rst_n(rst_n), .src_x(src_x), .src_y(src_y),
    .issue_valid(issue_valid), .issue_dst_x(issue_dst_x), .issue_dst_y(issue_dst_y),
    .issue_ready(issue_ready), .issue_tag(issue_tag), .prio_valid(prio_valid),
    .prio(prio), .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .cmpl_l2_miss(cmpl_l2_miss)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit   m_valid [NE];
  bit   m_pm    [NE];
  int   m_hops  [NE];
  logic [3:0] m_hist = '0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic bit m_predict();
    int n = 0;
    for (int i = 0; i < 4; i++) n += m_hist[i];
    return n >= 2;
  endfunction

  function automatic int m_free_idx();
    for (int i = 0; i < NE; i++) if (!m_valid[i]) return i;
    return -1;
  endfunction

  // Drive an issue (optionally with a completion in the same cycle) and check outputs
  task automatic step(bit do_iss, int dx, int dy, bit do_cm, int ctag, bit cmiss);
    int own, mx, cnt, d, fi;
    bit pm;
    @(negedge clk);
    issue_valid = do_iss; issue_dst_x = 3'(dx); issue_dst_y = 3'(dy);
    cmpl_valid = do_cm; cmpl_tag = 3'(ctag); cmpl_l2_miss = cmiss;
    #2;
    fi  = m_free_idx();
    own = absd(dx, int'(src_x)) + absd(dy, int'(src_y));
    mx = 0; cnt = 0;
    for (int i = 0; i < NE; i++) if (m_valid[i]) begin
      if (m_hops[i] > mx) mx = m_hops[i];
      cnt += m_pm[i];
    end
    pm = m_predict();
    d = mx - own; if (d < 0) d = 0; if (d > 3) d = 3;
    if (cnt > 3) cnt = 3;
    check("R7 ready", int'(issue_ready), (fi >= 0) ? 1 : 0);
    check("R10 prio_valid", int'(prio_valid), (do_iss && fi >= 0) ? 1 : 0);
    if (do_iss && fi >= 0) begin
      check("R7 tag", int'(issue_tag), fi);
      check("R2/R3 hop slack", int'(prio[1:0]), d);
      check("R4 miss count", int'(prio[4:3]), cnt);
      check("R5/R6/R9 own hit", int'(prio[2]), pm ? 0 : 1);
    end
    @(posedge clk);
    if (do_cm && m_valid[ctag]) begin
      m_valid[ctag] = 0;
      m_hist = {m_hist[2:0], cmiss};
    end
    if (do_iss && fi >= 0) begin
      m_valid[fi] = 1; m_pm[fi] = pm; m_hops[fi] = own;
    end
    #1;
    issue_valid = 1'b0; cmpl_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_pm[i] = 0; m_hops[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, and the first priority from an empty table
    @(negedge clk);
    check("R1 ready after reset", int'(issue_ready), 1);
    issue_valid = 1'b1; issue_dst_x = 3'd7; issue_dst_y = 3'd0; #2;
    check("R1 first prio", int'(prio), 5'b00100);
    issue_valid = 1'b0;

    // R2 R3: predecessor destination over the whole grid, own destination over a diagonal
    for (int sc = 0; sc < 2; sc++) begin
      src_x = sc ? 3'd0 : 3'd3; src_y = sc ? 3'd7 : 3'd4;
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 8; b++) begin
          step(1, a % 8, a / 8, 0, 0, 0);
          step(1, b, 7 - b, 0, 0, 0);
          step(0, 0, 0, 1, 0, (a + b) % 3 == 0);
          step(0, 0, 0, 1, 1, b[0]);
        end
      end
    end
    src_x = 3'd3; src_y = 3'd4;

    // R6: every 4-outcome history against the threshold
    for (int p = 0; p < 16; p++) begin
      for (int k = 3; k >= 0; k--) begin
        step(1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, p[k]);
      end
      step(1, 5, 2, 0, 0, 0);
      step(0, 0, 0, 1, 0, 1'b1);
    end

    // R4 R7: fill the table with predicted misses, then try a ninth issue
    for (int k = 0; k < 4; k++) begin step(1, 0, 0, 0, 0, 0); step(0, 0, 0, 1, 0, 1); end
    for (int k = 0; k < NE; k++) step(1, k, k, 0, 0, 0);
    step(1, 2, 2, 0, 0, 0);
    check("R7 full ready low", int'(issue_ready), 0);

    // R8: free slot 5, repeat the completion (ignored), reissue into slot 5
    step(0, 0, 0, 1, 5, 0);
    step(0, 0, 0, 1, 5, 0);
    step(0, 0, 0, 1, 5, 0);
    step(1, 6, 6, 0, 0, 0);
    step(1, 6, 6, 0, 0, 0);

    // R9: completion and issue in one cycle while full, then while one slot free
    step(1, 3, 3, 1, 2, 0);
    step(1, 0, 7, 1, 0, 1);
    step(1, 7, 7, 0, 0, 0);
    for (int k = 0; k < NE; k++) step(0, 0, 0, 1, k, 0);
    step(1, 3, 4, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule